// File: doc/BRIEF.md
# Programmable Power-of-Two Clock Divider

This block derives a gated, divided clock from a reference clock. Software selects the ratio through a three-bit exponent code held in a byte-wide control register, and it starts or stops the divided clock through a single bit in a second register. Both registers sit at fixed offsets from an instance base address, which is a parameter. Neighbouring instances are spaced 0x100 apart and share the same layout, so an address belonging to another instance is simply ignored here.

Starting and stopping are governed by a four-state gating machine. IDLE holds the output low. When IDLE sees the enable bit set, it captures the ratio and moves to WARMUP. WARMUP counts a fixed start delay that depends on the ratio. When that count completes it moves to RUN. If enable is cleared first, it returns to IDLE without ever opening the gate. RUN drives the divided clock. When RUN sees enable cleared, it waits for the end of the current divided period and then moves to SETTLE. SETTLE holds the output low until the stop window has passed, then returns to IDLE.

The register bus is a simple byte-wide interface with an address, write data, a write strobe and a combinational read-data port. A status output reports whether the gate is open, so start and stop latencies can be measured.

Top module: `pow2_clkdiv`

## Requirements
- R1: After reset, both registers read 0x00, `clk_out` is low and `gate_active` is low.
- R2: The ratio register sits at base+0x43 and holds the code in bits [2:0]. Bits [7:3] read as zero and ignore writes.
- R3: The enable register sits at base+0x46 and holds the enable in bit 7, which reads back as written. Bits [6:0] read as zero and ignore writes.
- R4: The division ratio is 2^(code-1), so code 7 gives 64. Code 0 behaves like code 1, which is divide-by-1. For a ratio div ≥ 2, `clk_out` is high for the first div/2 reference cycles of each period and low for the rest. At divide-by-1, `clk_out` follows the reference clock.
- R5: `gate_active` rises exactly 2+3·div reference edges after the edge that writes enable=1.
- R6: After the edge that writes enable=0, `gate_active` falls within 3·div reference edges. After that, `clk_out` stays low.
- R7: The gate opens and closes only on divided-period boundaries. Every high phase is full length, and the output always stops low.
- R8: A code written while the clock runs has no effect on the output. The next enable uses the new ratio, including the start latency of the new ratio.
- R9: Writes to any address other than the two registers of this instance change nothing, and such addresses read as 0x00.
- R10: If enable is cleared while the start delay is still counting, the gate never opens and `clk_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising reference edge |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| clk_out | output | 1 | Gated, divided clock |
| gate_active | output | 1 | High while the gate is open (RUN state) |

## Verification
The assertions assume that reset is applied before any bus traffic. They also assume that enable is not set again before the SETTLE window has closed, because an early re-enable would only be held off. The bench therefore always waits more than 3·div cycles after each disable before it writes again. It drives every bus signal at points well away from the rising edge, so each write lands on one known edge from which the latencies are counted. It sweeps all eight codes, and it does this with the enable held steady through WARMUP. The one exception is a deliberate abort test.

// File: rtl/pow2div_pkg.sv
package pow2div_pkg;

    typedef enum logic [1:0] {
        GS_IDLE,
        GS_WARMUP,
        GS_RUN,
        GS_SETTLE
    } gate_state_e;

    // exponent code to shift amount; code 0 aliases to code 1
    function automatic int unsigned code_to_shift(input int unsigned code);
        return (code == 0) ? 0 : code - 1;
    endfunction

endpackage

// File: rtl/pow2div_regs.sv
module pow2div_regs #(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter int unsigned BASE_ADDR  = 'h0400,
    parameter int unsigned DIV_OFFSET = 'h43,
    parameter int unsigned EN_OFFSET  = 'h46,
    parameter int          EN_BIT     = 7,
    parameter int          CODE_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en_q,
    output logic [CODE_W-1:0] code_q
);

    localparam logic [ADDR_W-1:0] DIV_ADDR = ADDR_W'(BASE_ADDR + DIV_OFFSET);
    localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(BASE_ADDR + EN_OFFSET);

    logic hit_div;
    logic hit_en;
    logic unused_wdata;

    assign hit_div      = (bus_addr == DIV_ADDR);
    assign hit_en       = (bus_addr == EN_ADDR);
    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            code_q <= '0;
        end else begin
            if (bus_we && hit_div) begin
                code_q <= bus_wdata[CODE_W-1:0];
            end
            if (bus_we && hit_en) begin
                en_q <= bus_wdata[EN_BIT];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_div) begin
            bus_rdata[CODE_W-1:0] = code_q;
        end
        if (hit_en) begin
            bus_rdata[EN_BIT] = en_q;
        end
    end

    // R3
    en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_en) |=> (en_q == $past(bus_wdata[EN_BIT])));

    // R9
    foreign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !hit_en && !hit_div) |=> ($stable(en_q) && $stable(code_q)));

endmodule

// File: rtl/pow2div_fsm.sv
module pow2div_fsm
    import pow2div_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int SH_W   = 3,
    parameter int LAT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_q,
    input  logic [CODE_W-1:0] code_q,
    input  logic              phase_last,
    output logic [SH_W-1:0]   shift_q,
    output logic              running,
    output logic              load,
    output logic              run_next
);

    gate_state_e state;
    gate_state_e nxt;

    logic [LAT_W-1:0] cnt;
    logic [LAT_W-1:0] scnt;
    logic [LAT_W-1:0] div_now;
    logic [LAT_W-1:0] start_lat;
    logic [LAT_W-1:0] stop_lat;
    logic [SH_W-1:0]  cap_shift;

    assign div_now   = LAT_W'(1) << shift_q;
    assign start_lat = LAT_W'(2) + LAT_W'(3) * div_now;
    assign stop_lat  = LAT_W'(3) * div_now;
    assign cap_shift = SH_W'(code_to_shift(int'(code_q)));

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            GS_IDLE:   nxt = en_q ? GS_WARMUP : GS_IDLE;
            GS_WARMUP: begin
                if (!en_q) begin
                    nxt = GS_IDLE;
                end else if (cnt == start_lat - LAT_W'(2)) begin
                    nxt = GS_RUN;
                end
            end
            GS_RUN:    nxt = (!en_q && phase_last) ? GS_SETTLE : GS_RUN;
            GS_SETTLE: nxt = (scnt >= stop_lat - LAT_W'(1)) ? GS_IDLE : GS_SETTLE;
            default:   nxt = GS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GS_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // counters and ratio capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            scnt    <= '0;
            shift_q <= '0;
        end else begin
            if (state == GS_IDLE && en_q) begin
                shift_q <= cap_shift;
            end
            if (state == GS_WARMUP) begin
                cnt <= cnt + LAT_W'(1);
            end else begin
                cnt <= '0;
            end
            if (state == GS_RUN) begin
                scnt <= en_q ? '0 : scnt + LAT_W'(1);
            end else if (state == GS_SETTLE) begin
                scnt <= scnt + LAT_W'(1);
            end else begin
                scnt <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        running  = (state == GS_RUN);
        run_next = (nxt == GS_RUN);
        load     = (state == GS_WARMUP) && (nxt == GS_RUN);
    end

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != GS_IDLE) |=> $stable(shift_q));

    // R5
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> ($past(state) == GS_WARMUP && $past(en_q)));

    // R6
    stop_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GS_RUN) |-> (scnt < stop_lat));

endmodule

// File: rtl/pow2div_phase.sv
module pow2div_phase #(
    parameter int SH_W = 3,
    parameter int PH_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SH_W-1:0] shift_q,
    input  logic            load,
    input  logic            run_next,
    output logic            phase_last,
    output logic            hi_q
);

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] ph_next;
    logic [PH_W-1:0] last_val;
    logic [PH_W-1:0] half_m;
    logic            hi_load;
    logic            hi_step;

    always_comb begin
        last_val   = (PH_W'(1) << shift_q) - PH_W'(1);
        half_m     = (PH_W'(1) << shift_q) >> 1;
        phase_last = (phase == last_val);
        ph_next    = phase_last ? '0 : phase + PH_W'(1);
        hi_load    = (shift_q != '0);
        hi_step    = (shift_q != '0) && ((ph_next & half_m) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
            hi_q  <= 1'b0;
        end else if (load) begin
            phase <= '0;
            hi_q  <= hi_load;
        end else if (run_next) begin
            phase <= ph_next;
            hi_q  <= hi_step;
        end else begin
            phase <= '0;
            hi_q  <= 1'b0;
        end
    end

    // R7
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_q) |-> (phase == '0));

    // R7
    fall_at_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hi_q) |-> (phase == half_m));

endmodule

// File: rtl/pow2div_outgate.sv
module pow2div_outgate #(
    parameter int SH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            running,
    input  logic            hi_q,
    input  logic [SH_W-1:0] shift_q,
    output logic            clk_out
);

    logic gate_lo;

    // enable retimed on the falling edge so the AND cannot clip a high phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_lo <= 1'b0;
        end else begin
            gate_lo <= running;
        end
    end

    assign clk_out = (shift_q == '0) ? (clk & gate_lo) : hi_q;

    // R6
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !hi_q);

endmodule

// File: rtl/pow2_clkdiv.sv
module pow2_clkdiv #(
    parameter int          ADDR_W     = 16,
    parameter int unsigned BASE_ADDR  = 'h0400,
    parameter int unsigned DIV_OFFSET = 'h43,
    parameter int unsigned EN_OFFSET  = 'h46,
    parameter int          EN_BIT     = 7,
    parameter int          CODE_W     = 3
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    output logic              clk_out,
    output logic              gate_active
);

    localparam int SHIFT_MAX = (1 << CODE_W) - 2;
    localparam int MAX_DIV   = 1 << SHIFT_MAX;
    localparam int SH_W      = $clog2(SHIFT_MAX + 1);
    localparam int PH_W      = SHIFT_MAX + 1;
    localparam int LAT_W     = $clog2(3 * MAX_DIV + 3);

    logic              en_q;
    logic [CODE_W-1:0] code_q;
    logic [SH_W-1:0]   shift_q;
    logic              running;
    logic              load;
    logic              run_next;
    logic              phase_last;
    logic              hi_q;

    pow2div_regs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (8),
        .BASE_ADDR  (BASE_ADDR),
        .DIV_OFFSET (DIV_OFFSET),
        .EN_OFFSET  (EN_OFFSET),
        .EN_BIT     (EN_BIT),
        .CODE_W     (CODE_W)
    ) u_regs (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .en_q      (en_q),
        .code_q    (code_q)
    );

    pow2div_fsm #(
        .CODE_W (CODE_W),
        .SH_W   (SH_W),
        .LAT_W  (LAT_W)
    ) u_fsm (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .en_q       (en_q),
        .code_q     (code_q),
        .phase_last (phase_last),
        .shift_q    (shift_q),
        .running    (running),
        .load       (load),
        .run_next   (run_next)
    );

    pow2div_phase #(
        .SH_W (SH_W),
        .PH_W (PH_W)
    ) u_phase (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .shift_q    (shift_q),
        .load       (load),
        .run_next   (run_next),
        .phase_last (phase_last),
        .hi_q       (hi_q)
    );

    pow2div_outgate #(
        .SH_W (SH_W)
    ) u_gate (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .running (running),
        .hi_q    (hi_q),
        .shift_q (shift_q),
        .clk_out (clk_out)
    );

    assign gate_active = running;

endmodule

// File: tb/test_pow2_clkdiv.sv
module test_pow2_clkdiv;

    localparam int          CLK_PERIOD = 10;
    localparam int unsigned BASE       = 'h0400;
    localparam logic [15:0] DIV_A      = 16'(BASE + 'h43);
    localparam logic [15:0] EN_A       = 16'(BASE + 'h46);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        we = 1'b0;
    logic [7:0]  rdata;
    logic        clk_out;
    logic        active;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    pow2_clkdiv #(.BASE_ADDR(BASE)) i_pow2_clkdiv (
        .ref_clk     (clk),
        .rst_n       (rst_n),
        .bus_addr    (addr),
        .bus_wdata   (wdata),
        .bus_we      (we),
        .bus_rdata   (rdata),
        .clk_out     (clk_out),
        .gate_active (active)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int div_of(input int code);
        return (code == 0) ? 1 : (1 << (code - 1));
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
        addr = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // counts edges after the write edge until gate_active reaches lvl
    task automatic wait_active(input logic lvl, input int limit, output int j);
        j = 0;
        while (j < limit) begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            j++;
            if (active == lvl) break;
        end
    endtask

    task automatic low_after_stop(input string req);
        @(posedge clk);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            check(clk_out == 1'b0, req, clk_out, 0);
            #(CLK_PERIOD / 2);
            check(clk_out == 1'b0, req, clk_out, 0);
        end
    endtask

    initial begin
        logic [7:0] r;
        int j;
        int d;
        int d2;
        int c2;
        bit seen;

        idle(3);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(DIV_A, r);
        check(r == 8'h00, "R1 ratio reg", r, 0);
        rd(EN_A, r);
        check(r == 8'h00, "R1 enable reg", r, 0);
        check(clk_out == 1'b0, "R1 clk_out", clk_out, 0);
        check(active == 1'b0, "R1 gate_active", active, 0);

        // R2 unused ratio bits
        wr(DIV_A, 8'hFF);
        rd(DIV_A, r);
        check(r == 8'h07, "R2 pad bits", r, 7);
        wr(DIV_A, 8'hF8);
        rd(DIV_A, r);
        check(r == 8'h00, "R2 pad bits", r, 0);

        // R3 only bit 7 of enable register
        wr(EN_A, 8'h7F);
        rd(EN_A, r);
        check(r == 8'h00, "R3 enable pad", r, 0);
        idle(20);
        #(CLK_PERIOD / 4);
        check(active == 1'b0, "R3 no start", active, 0);

        // R9 foreign addresses
        wr(EN_A + 16'h0100, 8'h80);
        wr(DIV_A + 16'h0100, 8'h05);
        wr(DIV_A + 16'h0001, 8'h05);
        rd(EN_A, r);
        check(r == 8'h00, "R9 enable untouched", r, 0);
        rd(DIV_A, r);
        check(r == 8'h00, "R9 ratio untouched", r, 0);
        rd(EN_A + 16'h0100, r);
        check(r == 8'h00, "R9 foreign read", r, 0);
        idle(20);
        #(CLK_PERIOD / 4);
        check(active == 1'b0, "R9 no start", active, 0);

        // sweep every code
        for (int code = 0; code < 8; code++) begin
            d  = div_of(code);
            c2 = (code + 3) % 8;
            d2 = div_of(c2);
            wr(DIV_A, 8'(code));
            rd(DIV_A, r);
            check(r == 8'(code), "R2 readback", r, code);
            wr(EN_A, 8'h80);
            rd(EN_A, r);
            check(r == 8'h80, "R3 readback", r, 128);
            // wr returned one half cycle after the write edge; rd used one more edge
            wait_active(1'b1, 600, j);
            check(j + 1 == 2 + 3 * d, "R5 start latency", j + 1, 2 + 3 * d);
            // pattern from RUN entry (n = 0), code rewritten mid-run
            for (int n = 1; n <= 4 * d + 2; n++) begin
                logic e_hi;
                @(posedge clk);
                #(CLK_PERIOD / 4);
                e_hi = (d == 1) ? 1'b1 : ((n % d) < d / 2);
                check(clk_out == e_hi, (n > d) ? "R8 old ratio kept" : "R4 high half",
                      clk_out, e_hi);
                #(CLK_PERIOD / 2);
                check(clk_out == ((d == 1) ? 1'b0 : e_hi), "R4 low half", clk_out,
                      (d == 1) ? 0 : e_hi);
                if (n == d) begin
                    addr  = DIV_A;
                    wdata = 8'(c2);
                    we    = 1'b1;
                end else if (n == d + 1) begin
                    we   = 1'b0;
                    addr = '0;
                end
            end
            wr(EN_A, 8'h00);
            wait_active(1'b0, 600, j);
            check(j >= 1 && j <= 3 * d, "R6 stop latency", j, 3 * d);
            low_after_stop("R7 stopped low");
            idle(3 * d + 4);
            // R8 next enable uses the new ratio
            wr(EN_A, 8'h80);
            wait_active(1'b1, 600, j);
            check(j == 2 + 3 * d2, "R8 new ratio latency", j, 2 + 3 * d2);
            wr(EN_A, 8'h00);
            wait_active(1'b0, 600, j);
            check(j >= 1 && j <= 3 * d2, "R6 stop latency", j, 3 * d2);
            low_after_stop("R6 stopped low");
            idle(3 * d2 + 4);
        end

        // R10 abort during warm-up
        wr(DIV_A, 8'h03);
        wr(EN_A, 8'h80);
        wr(EN_A, 8'h00);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (active || clk_out) seen = 1'b1;
        end
        check(!seen, "R10 aborted start", seen, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule